// File: doc/BRIEF.md
# Four-Level Page Table Walker

The block converts a 64-bit virtual address into a physical address by walking four levels of translation tables kept in memory. Every table holds 512 entries of eight bytes. The walk starts from the page number of the root table, supplied by a control register. At each level the walker uses nine bits of the virtual address to pick an entry, then follows that entry's frame number down to the next table. The page offset passes through to the result unchanged.

Each request carries an access kind (read or write) and a privilege mode (user or supervisor). The walker keeps a running AND of the writable and user permissions seen along the path and stops at the first level that denies the access. It marks each entry it passes through as accessed. On a write it also marks the final entry dirty. These marks are written back through the same memory port the walker reads from.

That port allows one transaction outstanding at a time. It returns 64-bit entries. A walk ends with a single-cycle done pulse and the physical address, or with a single-cycle fault pulse and a 2-bit cause.

Top module: `pgw_walker`

## Requirements
- R1: If bits 63:47 of a request address are not all equal, the walker raises fault with cause 2'b01 in the next cycle. In that case it issues no memory access and busy stays low.
- R2: The walk reads level 4 first and level 1 last. Each entry is read at table base + index×8. The level-4 index is address bits 47:39, level 3 is 38:30, level 2 is 29:21 and level 1 is 20:12. The first table base is the root page number shifted left by 12. Each later table base is bits 51:12 of the entry above it.
- R3: If an entry has bit 0 (present) clear, the walk ends with fault cause 2'b10. No deeper level is read.
- R4: A write access ends with fault cause 2'b11 unless bit 1 (writable) is set at every level. A read access ignores bit 1.
- R5: A user-mode access ends with fault cause 2'b11 unless bit 2 (user) is set at every level. A supervisor access ignores bit 2.
- R6: Every visited entry that passes the present and permission checks and has bit 5 (accessed) clear is written back with bit 5 set. No other bit of that entry changes. An entry that already has bit 5 set is not written.
- R7: On a write access the level-1 entry is written back with bit 6 (dirty) set. A read access never sets bit 6, and no higher-level entry gets bit 6 from the walker.
- R8: A successful walk pulses done for one cycle. The physical address output then equals bits 51:12 of the level-1 entry joined with virtual address bits 11:0.
- R9: Busy rises on the cycle after a canonical request is taken. It stays high until the cycle in which done or fault pulses. A request presented while busy is ignored.
- R10: Memory reads and writes never overlap. Once a request is raised, it and its address stay unchanged until the acknowledge arrives. All entry addresses are 8-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request; taken only while idle |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| root_ppn | input | 40 | Page number of the level-4 table |
| busy | output | 1 | High while a walk is in progress |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: translation failed |
| fault_cause | output | 2 | 01 non-canonical, 10 not present, 11 protection |
| pa_out | output | 52 | Physical address of the last successful walk |
| mem_rd_req | output | 1 | Entry read request, held until acknowledged |
| mem_wr_req | output | 1 | Entry write-back request, held until acknowledged |
| mem_addr | output | 52 | Byte address of the entry |
| mem_wdata | output | 64 | Entry value to write back |
| mem_ack | input | 1 | One-cycle acknowledge of the pending request |
| mem_rdata | input | 64 | Entry value, valid with mem_ack on a read |

## Verification
The assertions assume the memory side pulses mem_ack for exactly one cycle, and only while a request is raised. They also assume that mem_rdata is valid in that same cycle and that root_ppn and req_vaddr are sampled only in the cycle a request is taken. The bench memory model follows these rules: it counts a fixed latency from the raised request, acknowledges once, and then drops the acknowledge. The bench drives requests on falling edges and changes the root only between walks. Its one deliberate out-of-window stimulus is a second request raised in the middle of a walk, which checks that the block ignores it.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE     = 2'b00,
      CAUSE_NONCANON = 2'b01,
      CAUSE_ABSENT   = 2'b10,
      CAUSE_PERM     = 2'b11
   } pgw_cause_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_MARK  = 2'd2
   } pgw_state_e;

   localparam int unsigned BIT_PRESENT  = 0;
   localparam int unsigned BIT_WRITE    = 1;
   localparam int unsigned BIT_USER     = 2;
   localparam int unsigned BIT_ACCESSED = 5;
   localparam int unsigned BIT_DIRTY    = 6;

endpackage

// File: rtl/pgw_canon_chk.sv
module pgw_canon_chk #(
   parameter int unsigned VA_W       = 64,
   parameter int unsigned WALK_W     = 48,
   parameter bit          CANON_CHECK = 1'b1
) (
   input  logic [VA_W-1:0] vaddr,
   output logic            canonical
);
   localparam int unsigned EXT_W = VA_W - WALK_W + 1;

   initial begin
      assert (WALK_W >= 2 && WALK_W <= VA_W)
         else $error("pgw_canon_chk: WALK_W out of range");
   end

   logic [EXT_W-1:0] ext_bits;
   assign ext_bits = vaddr[VA_W-1:WALK_W-1];

   generate
      if (CANON_CHECK) begin : g_check
         assign canonical = (&ext_bits) | ~(|ext_bits);
      end else begin : g_pass
         logic unused_ext;
         assign unused_ext = ^ext_bits;
         assign canonical  = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/pgw_va_split.sv
module pgw_va_split #(
   parameter int unsigned IDX_W  = 9,
   parameter int unsigned OFF_W  = 12,
   parameter int unsigned LEVELS = 4,
   localparam int unsigned WALK_W = OFF_W + LEVELS * IDX_W
) (
   input  logic [WALK_W-1:0]       vaddr,
   output logic [LEVELS*IDX_W-1:0] idx_flat,
   output logic [OFF_W-1:0]        offset
);
   initial begin
      assert (LEVELS >= 2) else $error("pgw_va_split: need two or more levels");
      assert (IDX_W >= 1)  else $error("pgw_va_split: IDX_W must be positive");
   end

   assign offset = vaddr[OFF_W-1:0];

   generate
      for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
         assign idx_flat[lv*IDX_W +: IDX_W] = vaddr[OFF_W + lv*IDX_W +: IDX_W];
      end
   endgenerate

endmodule

// File: rtl/pgw_entry_eval.sv
module pgw_entry_eval
   import pgw_pkg::*;
#(
   parameter int unsigned ENTRY_W   = 64,
   parameter int unsigned PA_W      = 52,
   parameter int unsigned OFF_W     = 12,
   parameter bit          AD_UPDATE = 1'b1,
   localparam int unsigned PPN_W    = PA_W - OFF_W
) (
   input  logic [ENTRY_W-1:0] entry,
   input  logic               last_level,
   input  logic               acc_write,
   input  logic               acc_user,
   input  logic               w_chain_in,
   input  logic               u_chain_in,
   output logic               present,
   output logic               perm_ok,
   output logic               w_chain_out,
   output logic               u_chain_out,
   output logic               need_wb,
   output logic [ENTRY_W-1:0] entry_wb,
   output logic [PPN_W-1:0]   frame
);
   initial begin
      assert (PA_W <= ENTRY_W && PA_W > OFF_W)
         else $error("pgw_entry_eval: PA_W must fit the entry and exceed OFF_W");
      assert (BIT_DIRTY < OFF_W)
         else $error("pgw_entry_eval: flag bits must sit below the frame field");
   end

   assign present     = entry[BIT_PRESENT];
   assign w_chain_out = w_chain_in & entry[BIT_WRITE];
   assign u_chain_out = u_chain_in & entry[BIT_USER];
   assign perm_ok     = (~acc_write | w_chain_out) & (~acc_user | u_chain_out);
   assign frame       = entry[PA_W-1:OFF_W];

   generate
      if (AD_UPDATE) begin : g_mark
         logic set_acc;
         logic set_dirty;
         logic [ENTRY_W-1:0] or_mask;
         always_comb begin
            set_acc   = ~entry[BIT_ACCESSED];
            set_dirty = last_level & acc_write & ~entry[BIT_DIRTY];
            or_mask   = '0;
            or_mask[BIT_ACCESSED] = 1'b1;
            or_mask[BIT_DIRTY]    = last_level & acc_write;
         end
         assign need_wb  = set_acc | set_dirty;
         assign entry_wb = entry | or_mask;
      end else begin : g_nomark
         logic unused_mark;
         assign unused_mark = last_level;
         assign need_wb     = 1'b0;
         assign entry_wb    = entry;
      end
   endgenerate

endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
   import pgw_pkg::*;
#(
   parameter int unsigned VA_W        = 64,
   parameter int unsigned PA_W        = 52,
   parameter int unsigned ENTRY_W     = 64,
   parameter int unsigned IDX_W       = 9,
   parameter int unsigned OFF_W       = 12,
   parameter int unsigned LEVELS      = 4,
   parameter bit          AD_UPDATE   = 1'b1,
   parameter bit          CANON_CHECK = 1'b1,
   localparam int unsigned PPN_W      = PA_W - OFF_W,
   localparam int unsigned WALK_W     = OFF_W + LEVELS * IDX_W,
   localparam int unsigned LVL_W      = (LEVELS > 1) ? $clog2(LEVELS) : 1,
   localparam int unsigned ENT_SHIFT  = $clog2(ENTRY_W / 8)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic               req_write,
   input  logic               req_user,
   input  logic [PPN_W-1:0]   root_ppn,
   output logic               busy,
   output logic               done,
   output logic               fault,
   output logic [1:0]         fault_cause,
   output logic [PA_W-1:0]    pa_out,
   output logic               mem_rd_req,
   output logic               mem_wr_req,
   output logic [PA_W-1:0]    mem_addr,
   output logic [ENTRY_W-1:0] mem_wdata,
   input  logic               mem_ack,
   input  logic [ENTRY_W-1:0] mem_rdata
);
   localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

   initial begin
      assert (WALK_W < VA_W)
         else $error("pgw_walker: walked bits must leave a sign-extension field");
      assert (IDX_W + ENT_SHIFT <= OFF_W)
         else $error("pgw_walker: a table must fit in one page");
      assert (ENTRY_W % 8 == 0)
         else $error("pgw_walker: entries are whole bytes");
   end

   // walk state
   pgw_state_e         state_q;
   logic [LVL_W-1:0]   lvl_q;
   logic [PPN_W-1:0]   table_q;
   logic [WALK_W-1:0]  va_q;
   logic               wr_q;
   logic               us_q;
   logic               w_ok_q;
   logic               u_ok_q;
   logic [ENTRY_W-1:0] wb_q;
   logic               done_q;
   logic               fault_q;
   pgw_cause_e         cause_q;
   logic [PA_W-1:0]    pa_q;

   // helpers
   logic                    req_canon;
   logic [LEVELS*IDX_W-1:0] idx_flat;
   logic [OFF_W-1:0]        va_off;
   logic [IDX_W-1:0]        idx_cur;

   logic               ent_present;
   logic               ent_perm_ok;
   logic               ent_w_chain;
   logic               ent_u_chain;
   logic               ent_need_wb;
   logic [ENTRY_W-1:0] ent_wb;
   logic [PPN_W-1:0]   ent_frame;

   logic               fetch_ok;
   logic               step;
   logic [PPN_W-1:0]   step_frame;

   pgw_canon_chk #(
      .VA_W        (VA_W),
      .WALK_W      (WALK_W),
      .CANON_CHECK (CANON_CHECK)
   ) u_canon (
      .vaddr     (req_vaddr),
      .canonical (req_canon)
   );

   pgw_va_split #(
      .IDX_W  (IDX_W),
      .OFF_W  (OFF_W),
      .LEVELS (LEVELS)
   ) u_split (
      .vaddr    (va_q),
      .idx_flat (idx_flat),
      .offset   (va_off)
   );

   pgw_entry_eval #(
      .ENTRY_W   (ENTRY_W),
      .PA_W      (PA_W),
      .OFF_W     (OFF_W),
      .AD_UPDATE (AD_UPDATE)
   ) u_eval (
      .entry       (mem_rdata),
      .last_level  (lvl_q == '0),
      .acc_write   (wr_q),
      .acc_user    (us_q),
      .w_chain_in  (w_ok_q),
      .u_chain_in  (u_ok_q),
      .present     (ent_present),
      .perm_ok     (ent_perm_ok),
      .w_chain_out (ent_w_chain),
      .u_chain_out (ent_u_chain),
      .need_wb     (ent_need_wb),
      .entry_wb    (ent_wb),
      .frame       (ent_frame)
   );

   assign idx_cur = idx_flat[lvl_q*IDX_W +: IDX_W];

   // one transaction at a time; address derives from the current table and level
   assign mem_rd_req = (state_q == ST_FETCH);
   assign mem_wr_req = (state_q == ST_MARK);
   assign mem_addr   = (PA_W'(table_q) << OFF_W) | (PA_W'(idx_cur) << ENT_SHIFT);
   assign mem_wdata  = wb_q;

   assign fetch_ok = (state_q == ST_FETCH) & mem_ack & ent_present & ent_perm_ok;

   // advance to the next level (or finish) after a clean fetch or a finished write-back
   assign step       = (fetch_ok & ~ent_need_wb) | ((state_q == ST_MARK) & mem_ack);
   assign step_frame = (state_q == ST_MARK) ? wb_q[PA_W-1:OFF_W] : ent_frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         lvl_q   <= '0;
         table_q <= '0;
         va_q    <= '0;
         wr_q    <= 1'b0;
         us_q    <= 1'b0;
         w_ok_q  <= 1'b0;
         u_ok_q  <= 1'b0;
         wb_q    <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         cause_q <= CAUSE_NONE;
         pa_q    <= '0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (!req_canon) begin
                     fault_q <= 1'b1;
                     cause_q <= CAUSE_NONCANON;
                  end else begin
                     state_q <= ST_FETCH;
                     lvl_q   <= TOP_LVL;
                     table_q <= root_ppn;
                     va_q    <= req_vaddr[WALK_W-1:0];
                     wr_q    <= req_write;
                     us_q    <= req_user;
                     w_ok_q  <= 1'b1;
                     u_ok_q  <= 1'b1;
                     cause_q <= CAUSE_NONE;
                  end
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  if (!ent_present) begin
                     state_q <= ST_IDLE;
                     fault_q <= 1'b1;
                     cause_q <= CAUSE_ABSENT;
                  end else if (!ent_perm_ok) begin
                     state_q <= ST_IDLE;
                     fault_q <= 1'b1;
                     cause_q <= CAUSE_PERM;
                  end else begin
                     w_ok_q <= ent_w_chain;
                     u_ok_q <= ent_u_chain;
                     wb_q   <= ent_wb;
                     if (ent_need_wb) begin
                        state_q <= ST_MARK;
                     end
                  end
               end
            end
            ST_MARK: begin
               // completion handled by the step logic below
            end
            default: state_q <= ST_IDLE;
         endcase

         if (step) begin
            if (lvl_q == '0) begin
               state_q <= ST_IDLE;
               pa_q    <= {step_frame, va_off};
               done_q  <= 1'b1;
            end else begin
               state_q <= ST_FETCH;
               lvl_q   <= lvl_q - 1'b1;
               table_q <= step_frame;
            end
         end
      end
   end

   assign busy        = (state_q != ST_IDLE);
   assign done        = done_q;
   assign fault       = fault_q;
   assign fault_cause = cause_q;
   assign pa_out      = pa_q;

endmodule

// File: rtl/pgw_walk_checker.sv
module pgw_walk_checker #(
   parameter int unsigned VA_W   = 64,
   parameter int unsigned PA_W   = 52,
   parameter int unsigned IDX_W  = 9,
   parameter int unsigned OFF_W  = 12,
   parameter int unsigned LEVELS = 4,
   parameter int unsigned ENT_SHIFT = 3,
   localparam int unsigned PPN_W  = PA_W - OFF_W,
   localparam int unsigned WALK_W = OFF_W + LEVELS * IDX_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [VA_W-1:0]  req_vaddr,
   input logic [PPN_W-1:0] root_ppn,
   input logic             busy,
   input logic             done,
   input logic             fault,
   input logic [1:0]       fault_cause,
   input logic             mem_rd_req,
   input logic             mem_wr_req,
   input logic [PA_W-1:0]  mem_addr,
   input logic             mem_ack
);
   logic [VA_W-WALK_W:0] sx_bits;
   logic                 sx_ok;
   logic [IDX_W-1:0]     top_idx;
   logic                 take;

   assign sx_bits = req_vaddr[VA_W-1:WALK_W-1];
   assign sx_ok   = (&sx_bits) | ~(|sx_bits);
   assign top_idx = req_vaddr[WALK_W-1 -: IDX_W];
   assign take    = req_valid & ~busy;

   // R1: non-canonical request faults at once with no memory traffic
   a_r1_noncanon_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !sx_ok) |=> (fault && fault_cause == 2'b01 && !busy && !mem_rd_req));

   // R2: first read targets the root table slot picked by the top index
   a_r2_first_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (take && sx_ok) |=> (mem_rd_req && busy &&
         mem_addr == ((PA_W'($past(root_ppn)) << OFF_W) | (PA_W'($past(top_idx)) << ENT_SHIFT))));

   // R3: a fault always carries a cause
   a_r3_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (fault_cause != 2'b00));

   // R8: done is a lone pulse, never with fault, and the walker is idle then
   a_r8_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!fault && !busy));

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: busy only ends with a result
   a_r9_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done || fault));

   // R10: request held stable until acknowledged
   a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_ack) |=> (mem_rd_req && $stable(mem_addr)));

   a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && !mem_ack) |=> (mem_wr_req && $stable(mem_addr)));

   a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_req && mem_wr_req));

   a_r10_align: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req || mem_wr_req) |-> (busy && mem_addr[ENT_SHIFT-1:0] == '0));

endmodule

bind pgw_walker pgw_walk_checker #(
   .VA_W      (VA_W),
   .PA_W      (PA_W),
   .IDX_W     (IDX_W),
   .OFF_W     (OFF_W),
   .LEVELS    (LEVELS),
   .ENT_SHIFT (ENT_SHIFT)
) u_walk_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_vaddr   (req_vaddr),
   .root_ppn    (root_ppn),
   .busy        (busy),
   .done        (done),
   .fault       (fault),
   .fault_cause (fault_cause),
   .mem_rd_req  (mem_rd_req),
   .mem_wr_req  (mem_wr_req),
   .mem_addr    (mem_addr),
   .mem_ack     (mem_ack)
);

// File: tb/test_pgw_walker.sv
module test_pgw_walker;
   localparam int CLK_PERIOD = 10;
   localparam int MEM_LAT    = 2;
   localparam int WATCHDOG   = 100000;

   localparam logic [63:0] F_P = 64'h01;
   localparam logic [63:0] F_W = 64'h02;
   localparam logic [63:0] F_U = 64'h04;
   localparam logic [63:0] F_A = 64'h20;
   localparam logic [63:0] F_D = 64'h40;

   localparam logic [51:0] ROOT = 52'h0_0000_0010_0000;
   localparam logic [51:0] T3   = 52'h0_0000_0020_0000;
   localparam logic [51:0] T2   = 52'h0_0000_0030_0000;
   localparam logic [51:0] T1   = 52'h0_0000_0040_0000;
   localparam logic [51:0] PG   = 52'h0_000F_1234_5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic [39:0] root_ppn = ROOT[51:12];
   logic        busy, done, fault;
   logic [1:0]  fault_cause;
   logic [51:0] pa_out;
   logic        mem_rd_req, mem_wr_req;
   logic [51:0] mem_addr;
   logic [63:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [63:0] mem_rdata = '0;

   pgw_walker i_pgw_walker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_user(req_user), .root_ppn(root_ppn),
      .busy(busy), .done(done), .fault(fault), .fault_cause(fault_cause),
      .pa_out(pa_out), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // memory model
   logic [63:0] mem [logic [51:0]];
   int lat_cnt = 0;
   int rd_total = 0;
   int wr_total = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         lat_cnt <= 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
         lat_cnt <= 0;
      end else if (mem_rd_req || mem_wr_req) begin
         if (lat_cnt == MEM_LAT) begin
            mem_ack <= 1'b1;
            if (mem_rd_req) begin
               mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
               rd_total = rd_total + 1;
            end else begin
               mem[mem_addr] = mem_wdata;
               wr_total = wr_total + 1;
            end
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   // results of the last walk
   bit          r_done, r_fault, r_gap;
   logic [1:0]  r_cause;
   logic [51:0] r_pa;
   int          r_rd, r_wr;

   function automatic logic [51:0] slot(input logic [51:0] base, input logic [63:0] va, input int lvl);
      logic [8:0] ix;
      ix = va[12 + 9*(lvl-1) +: 9];
      return base + {40'd0, ix, 3'b000};
   endfunction

   function automatic logic [63:0] rd_mem(input logic [51:0] a);
      return mem.exists(a) ? mem[a] : 64'h0;
   endfunction

   task automatic check(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   // build a path; a zero flag word leaves that entry absent
   task automatic build(input logic [63:0] va, input logic [63:0] f4, input logic [63:0] f3,
                        input logic [63:0] f2, input logic [63:0] f1);
      mem.delete();
      if (f4 != 0) mem[slot(ROOT, va, 4)] = {12'd0, T3[51:12], 12'd0} | f4;
      if (f3 != 0) mem[slot(T3,   va, 3)] = {12'd0, T2[51:12], 12'd0} | f3;
      if (f2 != 0) mem[slot(T2,   va, 2)] = {12'd0, T1[51:12], 12'd0} | f2;
      if (f1 != 0) mem[slot(T1,   va, 1)] = {12'd0, PG[51:12], 12'd0} | f1;
   endtask

   task automatic walk(input logic [63:0] va, input bit wr, input bit usr,
                       input bit inject, input logic [63:0] inj_va);
      int rd0, wr0, n;
      rd0 = rd_total; wr0 = wr_total;
      r_gap = 1'b0; n = 0;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
      @(negedge clk);
      req_valid = 1'b0;
      while (!(done || fault) && n < 2000) begin
         if (!busy) r_gap = 1'b1;
         if (inject && n == 3) begin
            req_valid = 1'b1; req_vaddr = inj_va; req_write = 1'b1;
         end else begin
            req_valid = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      req_valid = 1'b0;
      r_done = done; r_fault = fault; r_cause = fault_cause; r_pa = pa_out;
      r_rd = rd_total - rd0; r_wr = wr_total - wr0;
      @(negedge clk);
   endtask

   localparam logic [63:0] VA1 = 64'h0000_1234_5678_9ABC;
   localparam logic [63:0] VAH = 64'hFFFF_9876_5432_1F0E;
   localparam logic [63:0] ALL = F_P | F_W | F_U | F_A;

   task automatic t_reset;
      check("R9", "busy after reset", {63'd0, busy}, 64'd0);
      check("R8", "done after reset", {63'd0, done}, 64'd0);
      check("R10", "rd req after reset", {63'd0, mem_rd_req}, 64'd0);
      check("R10", "wr req after reset", {63'd0, mem_wr_req}, 64'd0);
   endtask

   task automatic t_read_marked;
      build(VA1, ALL, ALL, ALL, ALL);
      walk(VA1, 1'b0, 1'b1, 1'b0, '0);
      check("R8", "done on clean read", {63'd0, r_done}, 64'd1);
      check("R8", "pa on clean read", {12'd0, r_pa}, {12'd0, PG[51:12], VA1[11:0]});
      check("R2", "four reads", r_rd, 4);
      check("R6", "no write when A set", r_wr, 0);
      check("R9", "busy held over walk", {63'd0, r_gap}, 64'd0);
   endtask

   task automatic t_accessed;
      build(VA1, F_P | F_W | F_U, F_P | F_W | F_U, F_P | F_W | F_U, F_P | F_W | F_U);
      walk(VA1, 1'b0, 1'b0, 1'b0, '0);
      check("R8", "done with A clear", {63'd0, r_done}, 64'd1);
      check("R6", "one write per level", r_wr, 4);
      check("R6", "L4 entry marked", rd_mem(slot(ROOT, VA1, 4)), {12'd0, T3[51:12], 12'd0} | F_P | F_W | F_U | F_A);
      check("R6", "L1 entry marked", rd_mem(slot(T1, VA1, 1)), {12'd0, PG[51:12], 12'd0} | F_P | F_W | F_U | F_A);
      check("R7", "read leaves D clear", rd_mem(slot(T1, VA1, 1)) & F_D, 64'd0);
   endtask

   task automatic t_dirty;
      build(VA1, ALL, ALL, ALL, ALL);
      walk(VA1, 1'b1, 1'b0, 1'b0, '0);
      check("R8", "done on write", {63'd0, r_done}, 64'd1);
      check("R7", "single dirty write", r_wr, 1);
      check("R7", "L1 entry dirty", rd_mem(slot(T1, VA1, 1)), {12'd0, PG[51:12], 12'd0} | ALL | F_D);
      check("R7", "L2 entry not dirty", rd_mem(slot(T2, VA1, 2)) & F_D, 64'd0);
   endtask

   task automatic t_absent;
      build(VA1, ALL, ALL, 64'd0, ALL);
      walk(VA1, 1'b0, 1'b0, 1'b0, '0);
      check("R3", "fault on absent L2", {63'd0, r_fault}, 64'd1);
      check("R3", "absent cause", {62'd0, r_cause}, 64'd2);
      check("R3", "stops after L2 read", r_rd, 3);
      check("R8", "no done on absent", {63'd0, r_done}, 64'd0);
   endtask

   task automatic t_readonly;
      build(VA1, ALL, F_P | F_U | F_A, ALL, ALL);
      walk(VA1, 1'b1, 1'b0, 1'b0, '0);
      check("R4", "write to read-only faults", {63'd0, r_fault}, 64'd1);
      check("R4", "protection cause", {62'd0, r_cause}, 64'd3);
      check("R4", "stops at L3", r_rd, 2);
      walk(VA1, 1'b0, 1'b0, 1'b0, '0);
      check("R4", "read of read-only ok", {63'd0, r_done}, 64'd1);
   endtask

   task automatic t_user;
      build(VA1, ALL, ALL, ALL, F_P | F_W | F_A);
      walk(VA1, 1'b0, 1'b1, 1'b0, '0);
      check("R5", "user on supervisor page faults", {63'd0, r_fault}, 64'd1);
      check("R5", "user cause", {62'd0, r_cause}, 64'd3);
      walk(VA1, 1'b0, 1'b0, 1'b0, '0);
      check("R5", "supervisor ignores U", {63'd0, r_done}, 64'd1);
      check("R5", "supervisor pa", {12'd0, r_pa}, {12'd0, PG[51:12], VA1[11:0]});
   endtask

   task automatic t_noncanon;
      build(VA1, ALL, ALL, ALL, ALL);
      walk(64'h0001_0000_0000_0000, 1'b0, 1'b0, 1'b0, '0);
      check("R1", "non-canonical faults", {63'd0, r_fault}, 64'd1);
      check("R1", "non-canonical cause", {62'd0, r_cause}, 64'd1);
      check("R1", "no memory reads", r_rd, 0);
      check("R1", "busy stayed low", {63'd0, busy}, 64'd0);
      walk(64'h8000_7FFF_0000_0000, 1'b0, 1'b0, 1'b0, '0);
      check("R1", "bit47 mismatch cause", {62'd0, r_cause}, 64'd1);
   endtask

   task automatic t_high_half;
      build(VAH, ALL, ALL, ALL, ALL);
      walk(VAH, 1'b0, 1'b0, 1'b0, '0);
      check("R1", "upper canonical accepted", {63'd0, r_done}, 64'd1);
      check("R2", "upper half pa", {12'd0, r_pa}, {12'd0, PG[51:12], VAH[11:0]});
   endtask

   task automatic t_ignore_busy;
      build(VA1, ALL, ALL, ALL, ALL);
      walk(VA1, 1'b0, 1'b0, 1'b1, 64'h0000_7777_0000_0123);
      check("R9", "walk finishes", {63'd0, r_done}, 64'd1);
      check("R9", "mid-walk request ignored", {12'd0, r_pa}, {12'd0, PG[51:12], VA1[11:0]});
      check("R9", "no extra write", r_wr, 0);
      check("R9", "no second walk", {62'd0, busy, fault}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_marked();
      t_accessed();
      t_dirty();
      t_absent();
      t_readonly();
      t_user();
      t_noncanon();
      t_high_half();
      t_ignore_busy();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule